// File: doc/BRIEF.md
# Multi-Bank Static Memory Controller

This block connects a simple internal request port to an asynchronous static-memory bus with four banks. Each bank has its own chip select. The controller drives a 24-bit byte address, a 32-bit bidirectional data bus, and active-low output-enable, write-enable and byte-lane strobes. A request carries a bank number, a byte address, a size (byte, halfword or word) and, for writes, data. The controller runs one or more bus cycles for the request, then pulses `rsp_done` for one cycle. For reads it also returns the assembled word.

Each bank has one configuration word, reached through a small word-indexed programming port. The word sets:
- the turnaround idle time,
- the read strobe length,
- the write strobe length,
- a write-protect flag,
- the data width of the bank.

Idle cycles are inserted when the bank changes or the transfer direction changes. When a request is wider than the bank, it is split into sequential narrow cycles. Read data is placed little-endian on byte lanes that match the address.

Top module: `smc_bank_ctrl`

## Requirements
- R1: After reset all chip selects, `mem_oe_n`, `mem_we_n` and every byte-lane strobe are high. The configuration words read back 0x0000FBEF, 0x2000FBEF, 0x1000FBEF and 0x0000FBEF for banks 0 to 3.
- R2: A configuration write stores the data masked with 0x3400FBFF into the word selected by `cfg_addr`. `cfg_rdata` returns the stored word of the bank selected by `cfg_addr`.
- R3: A read beat holds the bank's chip select and `mem_oe_n` low for bits [9:5] + 3 clocks, so a run of N read beats keeps `mem_oe_n` low for N times that length. Data is captured in the last clock of each beat.
- R4: A write beat lasts min(bits[15:11],16) + 3 clocks. `mem_we_n` is low during every clock of the beat except the last.
- R5: Idle clocks with all chip selects high are inserted before an access when its bank or its direction differs from the previous accepted access. The count is min(bits[4:0],16) + 1, taken from the new bank's word. No idle clocks are inserted otherwise, and none before the first access after reset. When a request is presented in the `rsp_done` cycle, the chip selects stay high for exactly one clock plus any idle clocks.
- R6: When bit 26 of a bank's word is set, a write to that bank produces no strobe activity. In the next cycle `rsp_done` and `rsp_err` are both high for one cycle.
- R7: Bits [29:28] of a bank's word select its width: 00 = 8 bits on data lines [7:0], 01 = 16 bits on [15:0], 10 or 11 = 32 bits.
- R8: A request whose size (0 = byte, 1 = half, 2 = word; 3 acts as word) is wider than the bank runs 2^(size−width) beats. The first beat is at the address aligned to the request size, and each later beat adds the bank width in bytes.
- R9: During a beat, the active-low byte-lane strobes select the lanes the beat touches:
  - 8-bit bank: lane 0 only.
  - 16-bit bank: lanes 1:0, or the single lane given by address bit 0 for a byte access.
  - 32-bit bank: all lanes for a word, address bit 1 picks the upper or lower lane pair for a half, and address bits 1:0 pick the lane for a byte.
- R10: The read response is little-endian and lane-aligned. Each beat's bus data, masked to the bank width, is shifted to the byte position given by the beat address within the word. Bytes not covered are zero, and the response of a write is zero.
- R11: Write data is taken lane-aligned from `req_wdata`. For each beat the bytes at the beat address's position within the word are shifted down onto the bank's lanes.
- R12: At most one chip select is low at a time, and `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_addr | input | 26 | Bank number [25:24], byte address [23:0] |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write to a protected bank |
| rsp_rdata | output | 32 | Assembled read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Bank configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| mem_addr | output | 24 | External byte address |
| mem_dq | inout | 32 | External data bus |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | 4 | Byte-lane strobes, active low |
| mem_cs_n | output | 4 | Chip selects, active low |

## Verification
The bench builds the block with four banks and a 24-bit address, as set by the defaults. With four banks it can give one bank each of the 8-bit, 16-bit and 32-bit widths and a fourth bank that is write-protected. It first checks the long reset-value timings and then reprograms short strobe and idle fields, so that splits, lane selection and turnaround gaps happen within a few clocks each. Saturated field values of 31 are also loaded, to cover the 19-clock write and 17-clock idle limits.

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl #(
  parameter int NBANK = 4,
  parameter int AW = 24,
  parameter logic [NBANK*32-1:0] CFG_RESET =
    {32'h0000FBEF, 32'h1000FBEF, 32'h2000FBEF, 32'h0000FBEF}
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW+$clog2(NBANK)-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic              cfg_we,
  input  logic [$clog2(NBANK)-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [AW-1:0]     mem_addr,
  inout  wire  [31:0]       mem_dq,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [3:0]        mem_bls_n,
  output logic [NBANK-1:0]  mem_cs_n
);
  localparam int BW = $clog2(NBANK);
  localparam logic [31:0] CFG_MASK = 32'h3400FBFF;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_STRB} st_t;

  function automatic logic [5:0] idle_len(input logic [4:0] f);
    return 6'(f > 5'd16 ? 5'd16 : f) + 6'd1;
  endfunction
  function automatic logic [5:0] rd_len(input logic [4:0] f);
    return 6'(f) + 6'd3;
  endfunction
  function automatic logic [5:0] wr_len(input logic [4:0] f);
    return 6'(f > 5'd16 ? 5'd16 : f) + 6'd3;
  endfunction
  function automatic logic [1:0] width_of(input logic [1:0] f);
    return (f == 2'b11) ? 2'd2 : f;
  endfunction

  logic [31:0] cfg [NBANK];
  st_t         st;
  logic [BW-1:0] bk, last_bk;
  logic        wr, last_wr, last_ok;
  logic [1:0]  sz, beat_left;
  logic [AW-1:0] adr;
  logic [31:0] wd, acc;
  logic [5:0]  cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) cfg[i] <= CFG_RESET[32*i +: 32] & CFG_MASK;
    end else if (cfg_we) begin
      cfg[cfg_addr] <= cfg_wdata & CFG_MASK;
    end

  assign cfg_rdata = cfg[cfg_addr];

  wire [BW-1:0] rq_bk   = req_addr[AW +: BW];
  wire          acc_go  = (st == S_IDLE) && req_valid;
  wire          wp_hit  = req_write && cfg[rq_bk][26];
  wire [1:0]    rs      = (req_size == 2'd3) ? 2'd2 : req_size;
  wire [1:0]    nw      = width_of(cfg[rq_bk][29:28]);
  wire          split   = rs > nw;
  wire [1:0]    diff    = rs - nw;
  wire          turn    = last_ok && ((last_bk != rq_bk) || (last_wr != req_write));
  wire [AW-1:0] start   = !split ? req_addr[AW-1:0] :
                          (rs == 2'd2) ? {req_addr[AW-1:2], 2'b00} : {req_addr[AW-1:1], 1'b0};
  wire [5:0]    nlen    = req_write ? wr_len(cfg[rq_bk][15:11]) : rd_len(cfg[rq_bk][9:5]);

  wire [1:0]    cw      = width_of(cfg[bk][29:28]);
  wire [5:0]    clen    = wr ? wr_len(cfg[bk][15:11]) : rd_len(cfg[bk][9:5]);
  wire          strb    = (st == S_STRB);
  wire [4:0]    sh      = (cw == 2'd0) ? {adr[1:0], 3'b000} :
                          (cw == 2'd1) ? {adr[1], 4'b0000} : 5'd0;
  wire [31:0]   wmask   = (cw == 2'd0) ? 32'h0000_00FF :
                          (cw == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  wire [31:0]   placed  = (mem_dq & wmask) << sh;
  wire [31:0]   dout    = wd >> sh;

  logic [3:0] lanes;
  always_comb begin
    if (cw == 2'd0)      lanes = 4'b0001;
    else if (cw == 2'd1) lanes = (sz == 2'd0) ? (adr[0] ? 4'b0010 : 4'b0001) : 4'b0011;
    else case (sz)
      2'd0:    lanes = 4'b0001 << adr[1:0];
      2'd1:    lanes = adr[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bk <= '0; wr <= 1'b0; sz <= '0; adr <= '0; wd <= '0;
      beat_left <= '0; cnt <= '0; acc <= '0;
      last_bk <= '0; last_wr <= 1'b0; last_ok <= 1'b0;
      rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        S_IDLE: if (acc_go) begin
          if (wp_hit) begin
            rsp_done  <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            bk <= rq_bk; wr <= req_write; sz <= rs; adr <= start; wd <= req_wdata;
            acc <= '0;
            beat_left <= !split ? 2'd0 : (diff == 2'd2) ? 2'd3 : 2'd1;
            last_bk <= rq_bk; last_wr <= req_write; last_ok <= 1'b1;
            if (turn) begin
              st  <= S_GAP;
              cnt <= idle_len(cfg[rq_bk][4:0]) - 6'd1;
            end else begin
              st  <= S_STRB;
              cnt <= nlen - 6'd1;
            end
          end
        end
        S_GAP: begin
          if (cnt == 6'd0) begin
            st  <= S_STRB;
            cnt <= clen - 6'd1;
          end else cnt <= cnt - 6'd1;
        end
        default: begin
          if (cnt != 6'd0) cnt <= cnt - 6'd1;
          else begin
            if (!wr) acc <= acc | placed;
            if (beat_left == 2'd0) begin
              st        <= S_IDLE;
              rsp_done  <= 1'b1;
              rsp_rdata <= wr ? 32'd0 : (acc | placed);
            end else begin
              beat_left <= beat_left - 2'd1;
              adr       <= adr + (AW'(1) << cw);
              cnt       <= clen - 6'd1;
            end
          end
        end
      endcase
    end

  assign req_ready = (st == S_IDLE);
  assign mem_addr  = adr;
  assign mem_cs_n  = strb ? ~(NBANK'(1) << bk) : '1;
  assign mem_oe_n  = !(strb && !wr);
  assign mem_we_n  = !(strb && wr && cnt != 6'd0);
  assign mem_bls_n = strb ? ~lanes : 4'b1111;
  assign mem_dq    = (strb && wr) ? dout : 'z;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R12
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) mem_oe_n || mem_we_n); // R12
  AST_WP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && req_write && cfg[rq_bk][26]) |=> (rsp_err && rsp_done && mem_we_n && (&mem_cs_n))); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_done); // R6
  AST_QUIET_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_cs_n) |-> ((&mem_bls_n) && mem_oe_n && mem_we_n)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> req_ready); // R5
endmodule

// File: tb/smc_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module smc_bank_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, cfg_we = 0;
  logic [1:0]  req_size = 0, cfg_addr = 0;
  logic [25:0] req_addr = 0;
  logic [31:0] req_wdata = 0, cfg_wdata = 0;
  wire         req_ready, rsp_done, rsp_err, mem_oe_n, mem_we_n;
  wire [31:0]  rsp_rdata, cfg_rdata;
  wire [23:0]  mem_addr;
  wire [31:0]  mem_dq;
  wire [3:0]   mem_bls_n, mem_cs_n;

  smc_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bls_n(mem_bls_n), .mem_cs_n(mem_cs_n));

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp); end
  endtask

  // memory model
  logic [7:0] mem [4][256];
  logic [1:0] tb_w [4];
  logic       tb_wp [4];
  logic [1:0] sel_b;
  logic [31:0] rd_val;
  logic        rd_drv;
  always_comb begin
    sel_b = 2'd0;
    for (int i = 0; i < 4; i++) if (!mem_cs_n[i]) sel_b = 2'(i);
    rd_drv = !(&mem_cs_n) && !mem_oe_n;
    case (tb_w[sel_b])
      2'd0: rd_val = {24'd0, mem[sel_b][mem_addr[7:0]]};
      2'd1: rd_val = {16'd0, mem[sel_b][{mem_addr[7:1], 1'b1}], mem[sel_b][{mem_addr[7:1], 1'b0}]};
      default: rd_val = {mem[sel_b][{mem_addr[7:2], 2'd3}], mem[sel_b][{mem_addr[7:2], 2'd2}],
                         mem[sel_b][{mem_addr[7:2], 2'd1}], mem[sel_b][{mem_addr[7:2], 2'd0}]};
    endcase
  end
  assign mem_dq = rd_drv ? rd_val : 'z;

  // monitor: write capture, run lengths, scoreboard
  logic [32:0] exp_q [$];
  int cs_lo_run = 0, cs_hi_run = 0, cs_lo_last = 0, cs_hi_last = 0;
  int oe_run = 0, oe_last = 0, we_run = 0, we_last = 0, we_falls = 0, viol = 0;
  logic prev_cs = 0, prev_oe = 0, prev_we = 0;
  logic [3:0] last_lanes = 0;
  always @(negedge clk) if (rst_n) begin
    logic cs_lo;
    cs_lo = !(&mem_cs_n);
    if ($countones(~mem_cs_n) > 1 || (!mem_oe_n && !mem_we_n)) viol++;
    if (cs_lo) begin
      last_lanes = ~mem_bls_n;
      if (!prev_cs) begin cs_hi_last = cs_hi_run; cs_lo_run = 0; end
      cs_lo_run++; cs_hi_run = 0;
    end else begin
      if (prev_cs) cs_lo_last = cs_lo_run;
      cs_hi_run++;
    end
    prev_cs = cs_lo;
    if (!mem_oe_n) begin if (!prev_oe) oe_run = 0; oe_run++; end
    else if (prev_oe) oe_last = oe_run;
    prev_oe = !mem_oe_n;
    if (!mem_we_n) begin
      if (!prev_we) begin we_run = 0; we_falls++; end
      we_run++;
      case (tb_w[sel_b])
        2'd0: if (mem_bls_n[0] == 0) mem[sel_b][mem_addr[7:0]] = mem_dq[7:0];
        2'd1: begin
          if (!mem_bls_n[0]) mem[sel_b][{mem_addr[7:1], 1'b0}] = mem_dq[7:0];
          if (!mem_bls_n[1]) mem[sel_b][{mem_addr[7:1], 1'b1}] = mem_dq[15:8];
        end
        default: for (int l = 0; l < 4; l++)
          if (!mem_bls_n[l]) mem[sel_b][{mem_addr[7:2], 2'(l)}] = mem_dq[8*l +: 8];
      endcase
    end else if (prev_we) we_last = we_run;
    prev_we = !mem_we_n;
    if (rsp_done) begin
      if (exp_q.size() == 0) check(0, "R10 unexpected completion", rsp_rdata, 0);
      else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        check(rsp_err == e[32], "R6 error flag", 32'(rsp_err), 32'(e[32]));
        check(rsp_rdata == e[31:0], "R10 response data", rsp_rdata, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] exp_read(input int b, input logic [23:0] a, input int s);
    logic [31:0] r;
    int w, nb, bytes, start;
    r = 0; w = tb_w[b]; if (s == 3) s = 2;
    bytes = 1 << w;
    start = (s > w) ? (a & ~((1 << s) - 1)) : a;
    nb = (s > w) ? (1 << (s - w)) : 1;
    for (int k = 0; k < nb; k++) begin
      int base;
      base = (start + k * bytes) & ~(bytes - 1);
      for (int j = 0; j < bytes; j++) r[8*((base + j) & 3) +: 8] = mem[b][8'(base + j)];
    end
    return r;
  endfunction

  task automatic issue(input int b, input logic [23:0] a, input int s, input bit w, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_size = 2'(s); req_addr = {2'(b), a}; req_wdata = d;
    if (w) exp_q.push_back({tb_wp[b], 32'd0});
    else   exp_q.push_back({1'b0, exp_read(b, a, s)});
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_write(input int b, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'(b); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_check(input int b, input logic [31:0] v, input string tag);
    @(negedge clk);
    cfg_addr = 2'(b);
    #1 check(cfg_rdata == v, tag, cfg_rdata, v);
  endtask

  task automatic finish_run();
    check(viol == 0, "R12 cs/strobe exclusivity violations", 32'(viol), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    int wf;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 256; i++) mem[b][i] = 8'(i ^ (b << 6) ^ 8'h35);
    tb_w[0] = 0; tb_w[1] = 2; tb_w[2] = 1; tb_w[3] = 0;
    for (int b = 0; b < 4; b++) tb_wp[b] = 0;
    repeat (3) @(negedge clk);
    check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_bls_n == 4'hF, "R1 idle outputs in reset",
          {24'd0, mem_cs_n, mem_bls_n}, 32'h0000_00FF);
    rst_n = 1;
    cfg_check(0, 32'h0000FBEF, "R1 reset word bank0");
    cfg_check(1, 32'h2000FBEF, "R1 reset word bank1");
    cfg_check(2, 32'h1000FBEF, "R1 reset word bank2");
    cfg_check(3, 32'h0000FBEF, "R1 reset word bank3");

    issue(1, 24'h000008, 2, 0, 0); settle();
    check(oe_last == 34, "R3 default read strobe length", 32'(oe_last), 34);

    cfg_write(3, 32'hFFFF_FFFF);
    cfg_check(3, 32'h3400FBFF, "R2 masked readback");

    cfg_write(0, 32'h0000_0022); cfg_write(1, 32'h1000_1040);
    cfg_write(2, 32'h2000_0804); cfg_write(3, 32'h2400_0001);
    tb_w[0] = 0; tb_w[1] = 1; tb_w[2] = 2; tb_w[3] = 2; tb_wp[3] = 1;
    cfg_check(2, 32'h2000_0804, "R2 programmed word");

    issue(2, 24'h000010, 2, 1, 32'hA1B2C3D4); settle();
    check(we_last == 3, "R4 write strobe low clocks", 32'(we_last), 3);
    check(cs_lo_last == 4, "R4 write beat length", 32'(cs_lo_last), 4);
    check(last_lanes == 4'b1111, "R9 word lanes on 32-bit bank", 32'(last_lanes), 32'hF);
    issue(2, 24'h000010, 2, 0, 0); settle();
    check(oe_last == 3, "R3 programmed read length", 32'(oe_last), 3);

    wf = we_falls;
    issue(0, 24'h000020, 2, 1, 32'h11223344); settle();
    check(we_falls - wf == 4, "R8 four beats on 8-bit bank", 32'(we_falls - wf), 4);
    check(we_last == 2, "R4 narrow write strobe", 32'(we_last), 2);
    check(mem[0][8'h20] == 8'h44 && mem[0][8'h23] == 8'h11, "R11 byte order on 8-bit bank",
          {16'd0, mem[0][8'h23], mem[0][8'h20]}, 32'h1144);
    check(last_lanes == 4'b0001, "R9 lane 0 on 8-bit bank", 32'(last_lanes), 1);
    issue(0, 24'h000020, 2, 0, 0); settle();
    check(oe_last == 16, "R8 four read beats", 32'(oe_last), 16);
    issue(0, 24'h000022, 0, 0, 0); settle();

    issue(1, 24'h000040, 2, 0, 0); settle();
    check(oe_last == 10, "R7 16-bit bank splits word in two", 32'(oe_last), 10);
    issue(1, 24'h000042, 1, 1, 32'h5566_0000); settle();
    check(mem[1][8'h42] == 8'h66 && mem[1][8'h43] == 8'h55, "R11 upper half to 16-bit lanes",
          {16'd0, mem[1][8'h43], mem[1][8'h42]}, 32'h5566);
    check(last_lanes == 4'b0011, "R9 half lanes on 16-bit bank", 32'(last_lanes), 3);
    issue(1, 24'h000045, 0, 1, 32'h0000_AB00); settle();
    check(mem[1][8'h45] == 8'hAB && last_lanes == 4'b0010, "R9 odd byte lane on 16-bit bank",
          {mem[1][8'h45], 20'd0, last_lanes}, 32'hAB00_0002);
    issue(1, 24'h000044, 1, 0, 0); settle();

    issue(2, 24'h000013, 0, 1, 32'h9900_0000); settle();
    check(mem[2][8'h13] == 8'h99 && last_lanes == 4'b1000, "R9 lane 3 byte on 32-bit bank",
          {mem[2][8'h13], 20'd0, last_lanes}, 32'h9900_0008);
    issue(2, 24'h000012, 1, 0, 0); settle();

    wf = we_falls;
    issue(3, 24'h000004, 2, 1, 32'hDEADBEEF); settle();
    check(we_falls == wf && mem[3][8'h04] == 8'(8'h04 ^ 8'hC0 ^ 8'h35), "R6 protected write silent",
          32'(we_falls - wf), 0);
    issue(3, 24'h000004, 2, 0, 0); settle();

    issue(2, 24'h000000, 2, 0, 0); issue(2, 24'h000004, 2, 1, 32'h01020304); settle();
    check(cs_hi_last == 6, "R5 direction turnaround gap", 32'(cs_hi_last), 6);
    issue(2, 24'h000000, 2, 0, 0); issue(2, 24'h000008, 2, 0, 0); settle();
    check(cs_hi_last == 1, "R5 no gap same bank and direction", 32'(cs_hi_last), 1);
    issue(2, 24'h000000, 2, 0, 0); issue(1, 24'h000008, 1, 0, 0); settle();
    check(cs_hi_last == 2, "R5 bank change gap", 32'(cs_hi_last), 2);

    cfg_write(2, 32'h2000_F81F);
    issue(1, 24'h000008, 1, 0, 0); issue(2, 24'h000020, 2, 1, 32'h0A0B0C0D); settle();
    check(cs_hi_last == 18, "R5 saturated idle gap", 32'(cs_hi_last), 18);
    check(we_last == 18, "R4 saturated write length", 32'(we_last), 18);

    finish_run();
  end
endmodule